// File: doc/BRIEF.md
# PCI Express Power-State Traffic Gate

This block sits between the transaction layer of a PCI Express endpoint controller and the rest of the controller. It tracks the device power state and the link power state, and it decides which traffic may move in each state. Software sets the device state through a configuration write to the power-state field. The block then stalls or passes outbound requests and accepts or discards inbound transactions to match that state.

The block runs the turn-off handshake that leads into the deepest link state. It also leaves that state through a wake sequence. On the way out, it drives a general-purpose enable for an external tristate wake driver, because the controller has no beacon. A return from D3hot to D0 produces a one-cycle configuration-space reset pulse and a link-retrain request.

ASPM control is reduced to its L0s enable. In root-complex mode, a software command can request a PM_Turn_Off message while the device is out of D0.

Top module: `pm_traffic_gate`

## Requirements
- R1: After power-on reset (rst_n low), dev_state is 0 (D0) and link_state is 0 (L0). cfg_reset, link_retrain, to_ack_valid, wake_oe and turn_off_send are all 0.
- R2: In D0 (dev_state 0), tx_valid equals out_req_valid, out_req_ready equals tx_ready, and in_accept equals in_valid, with in_drop 0.
- R3: In D1, D2 or D3hot (dev_state 1, 2, 3), tx_valid and out_req_ready are 0, and out_stall equals out_req_valid. A held request is never dropped.
- R4: Out of D0, an inbound transaction of kind 0 (memory, I/O or completion) is dropped (in_drop 1). Kinds 1 (configuration), 2 (PME message) and 3 (PME_Turn_Off) are accepted (in_accept 1).
- R5: A write of 0 while dev_state is 3 sets dev_state to 0 at the next edge. On that same edge, cfg_reset and link_retrain rise together for exactly one cycle. A write that moves to D0 from any other state, or any other write, produces no pulse.
- R6: In D3hot, an inbound kind-3 message raises to_ack_valid at the next edge. The signal holds until to_ack_ready is seen. The edge that completes the handshake enters L2/L3 Ready (link_state 3) and clears to_ack_valid, and any power-state write in that cycle is ignored. A PME_Turn_Off seen outside D3hot is ignored. Leaving D3hot cancels a pending acknowledge.
- R7: In L2/L3 Ready, power-state writes are ignored. wake_req raises wake_oe at the next edge. The following edge leaves L2/L3 Ready for D0 and L0, pulses cfg_reset and link_retrain, and clears wake_oe.
- R8: Outside L2/L3 Ready, link_state is 2 (L1) whenever dev_state is not 0.
- R9: In D0, link_state becomes 1 (L0s) one edge after a cycle in which aspm_ctl bit 0 and link_idle are both 1. It becomes 0 one edge after either is 0. aspm_ctl bit 1 (the L1 ASPM enable) has no effect.
- R10: When rc_mode and sw_turn_off are both 1 while dev_state is not 0, turn_off_send is 1 for one cycle after the next edge. In D0, or with rc_mode 0, the command is ignored.
- R11: An outbound request held during a non-D0 state is presented on tx_valid in the first cycle after dev_state returns to 0. Requests leave in the order the source offers them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| cfg_pwr_wr | input | 1 | Configuration write to the power-state field |
| cfg_pwr_data | input | 2 | Written power state: 0 D0, 1 D1, 2 D2, 3 D3hot |
| aspm_ctl | input | 2 | ASPM control bits; bit 0 enables L0s, bit 1 is ignored |
| link_idle | input | 1 | Link has no pending activity |
| rc_mode | input | 1 | Controller acts as root complex |
| sw_turn_off | input | 1 | Software command to send PM_Turn_Off |
| in_valid | input | 1 | Inbound transaction present |
| in_kind | input | 2 | Inbound kind: 0 data, 1 configuration, 2 PME message, 3 PME_Turn_Off |
| in_accept | output | 1 | Inbound transaction is accepted |
| in_drop | output | 1 | Inbound transaction is discarded |
| out_req_valid | input | 1 | Outbound request offered by the source |
| out_req_ready | output | 1 | Outbound request taken from the source |
| out_stall | output | 1 | Outbound request held by the power state |
| tx_valid | output | 1 | Outbound request passed to the transmitter |
| tx_ready | input | 1 | Transmitter can take a request |
| to_ack_valid | output | 1 | PME_TO_Ack to be sent |
| to_ack_ready | input | 1 | PME_TO_Ack taken by the transmitter |
| turn_off_send | output | 1 | Request to emit PM_Turn_Off (root-complex mode) |
| wake_req | input | 1 | Local event asks to wake the link |
| wake_oe | output | 1 | Enable for the external tristate wake driver |
| cfg_reset | output | 1 | One-cycle configuration-space reset pulse |
| link_retrain | output | 1 | One-cycle link-training restart request |
| dev_state | output | 2 | Current device power state |
| link_state | output | 2 | Link state: 0 L0, 1 L0s, 2 L1, 3 L2/L3 Ready |

## Verification
The assertions assume the following about the inputs:
- to_ack_ready is only meaningful while to_ack_valid is high.
- in_kind is only meaningful while in_valid is high.
- rst_n is asserted at time zero, before any clock edge.

The stimulus keeps within these limits. Reset is applied only at the start. All inputs are driven on the falling edge from seeded $urandom draws. Directed sequences are inserted to reach the rare paths: the full turn-off handshake into L2/L3 Ready, the wake exit, a D1-to-D0 write with no pulse, the ignored L1 ASPM bit, and a request held across a return to D0.

// File: rtl/pm_traffic_gate.sv
module pm_traffic_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_pwr_wr,
  input  logic [1:0] cfg_pwr_data,
  input  logic [1:0] aspm_ctl,
  input  logic       link_idle,
  input  logic       rc_mode,
  input  logic       sw_turn_off,
  input  logic       in_valid,
  input  logic [1:0] in_kind,
  output logic       in_accept,
  output logic       in_drop,
  input  logic       out_req_valid,
  output logic       out_req_ready,
  output logic       out_stall,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic       to_ack_valid,
  input  logic       to_ack_ready,
  output logic       turn_off_send,
  input  logic       wake_req,
  output logic       wake_oe,
  output logic       cfg_reset,
  output logic       link_retrain,
  output logic [1:0] dev_state,
  output logic [1:0] link_state
);
  localparam logic [1:0] ST_D0 = 2'd0, ST_D3H = 2'd3;
  localparam logic [1:0] KD_DATA = 2'd0, KD_TOFF = 2'd3;
  localparam logic [1:0] LK_L0 = 2'd0, LK_L0S = 2'd1, LK_L1 = 2'd2, LK_L23 = 2'd3;

  logic [1:0] dstate_q, d_n;
  logic l23_q, l23_n, ack_q, ack_n, wake_q, wake_n;
  logic rst_q, rt_q, pulse_n, l0s_q, toff_q;

  wire gate_open = (dstate_q == ST_D0) && !l23_q;
  wire hs_done   = ack_q && to_ack_ready;
  wire toff_rx   = in_valid && (in_kind == KD_TOFF) && (dstate_q == ST_D3H) && !l23_q;

  always_comb begin
    d_n     = dstate_q;
    l23_n   = l23_q;
    ack_n   = ack_q;
    wake_n  = 1'b0;
    pulse_n = 1'b0;
    if (l23_q) begin
      if (wake_q) begin
        l23_n   = 1'b0;
        d_n     = ST_D0;
        pulse_n = 1'b1;
      end else begin
        wake_n = wake_req;
      end
    end else if (hs_done) begin
      l23_n = 1'b1;
      ack_n = 1'b0;
    end else begin
      if (cfg_pwr_wr) begin
        d_n     = cfg_pwr_data;
        pulse_n = (dstate_q == ST_D3H) && (cfg_pwr_data == ST_D0);
      end
      ack_n = (d_n == ST_D3H) && (ack_q || toff_rx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dstate_q <= ST_D0;
      l23_q    <= 1'b0;
      ack_q    <= 1'b0;
      wake_q   <= 1'b0;
      rst_q    <= 1'b0;
      rt_q     <= 1'b0;
      l0s_q    <= 1'b0;
      toff_q   <= 1'b0;
    end else begin
      dstate_q <= d_n;
      l23_q    <= l23_n;
      ack_q    <= ack_n;
      wake_q   <= wake_n;
      rst_q    <= pulse_n;
      rt_q     <= pulse_n;
      l0s_q    <= (d_n == ST_D0) && !l23_n && aspm_ctl[0] && link_idle;
      toff_q   <= rc_mode && sw_turn_off && (dstate_q != ST_D0);
    end
  end

  assign tx_valid      = out_req_valid && gate_open;
  assign out_req_ready = tx_ready && gate_open;
  assign out_stall     = out_req_valid && !gate_open;
  assign in_accept     = in_valid && ((dstate_q == ST_D0) || (in_kind != KD_DATA));
  assign in_drop       = in_valid && !in_accept;
  assign to_ack_valid  = ack_q;
  assign wake_oe       = wake_q;
  assign cfg_reset     = rst_q;
  assign link_retrain  = rt_q;
  assign turn_off_send = toff_q;
  assign dev_state     = dstate_q;
  assign link_state    = l23_q ? LK_L23 : (dstate_q != ST_D0) ? LK_L1 : l0s_q ? LK_L0S : LK_L0;

  a_r5_pulse_from_d3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |-> (dev_state == ST_D0) && ($past(dstate_q) == ST_D3H));
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> !cfg_reset);
  a_r6_l23_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l23_q) |-> $past(to_ack_valid && to_ack_ready && dev_state == ST_D3H));
  a_r6_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (to_ack_valid && !to_ack_ready && !cfg_pwr_wr) |=> to_ack_valid);
  a_r7_l23_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l23_q) |-> $past(wake_oe) && cfg_reset && (dev_state == ST_D0));
  a_r4_drop_kind: assert property (@(posedge clk) disable iff (!rst_n)
    in_drop |-> (in_kind == KD_DATA) && (dev_state != ST_D0));
  a_r9_l0s_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == LK_L0S) |-> $past(aspm_ctl[0] && link_idle));
  a_r3_no_tx_off_d0: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == LK_L1 || link_state == LK_L23) |-> !tx_valid && !out_req_ready);
endmodule

// File: tb/pm_traffic_gate_tb_top.sv
module pm_traffic_gate_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_pwr_wr, link_idle, rc_mode, sw_turn_off, in_valid;
  logic [1:0] cfg_pwr_data, aspm_ctl, in_kind;
  logic in_accept, in_drop, out_req_valid, out_req_ready, out_stall, tx_valid, tx_ready;
  logic to_ack_valid, to_ack_ready, turn_off_send, wake_req, wake_oe, cfg_reset, link_retrain;
  logic [1:0] dev_state, link_state;

  pm_traffic_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pwr_wr(cfg_pwr_wr), .cfg_pwr_data(cfg_pwr_data),
    .aspm_ctl(aspm_ctl), .link_idle(link_idle), .rc_mode(rc_mode), .sw_turn_off(sw_turn_off),
    .in_valid(in_valid), .in_kind(in_kind), .in_accept(in_accept), .in_drop(in_drop),
    .out_req_valid(out_req_valid), .out_req_ready(out_req_ready), .out_stall(out_stall),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .to_ack_valid(to_ack_valid),
    .to_ack_ready(to_ack_ready), .turn_off_send(turn_off_send), .wake_req(wake_req),
    .wake_oe(wake_oe), .cfg_reset(cfg_reset), .link_retrain(link_retrain),
    .dev_state(dev_state), .link_state(link_state));

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [1:0] m_d;
  logic m_l23, m_ack, m_wake, m_pulse, m_l0s, m_toff;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_link();
    if (m_l23) return 2'd3;
    if (m_d != 2'd0) return 2'd2;
    return m_l0s ? 2'd1 : 2'd0;
  endfunction

  function automatic logic exp_open();
    return (m_d == 2'd0) && !m_l23;
  endfunction

  task automatic check_all();
    chk("R2 R3 tx_valid", tx_valid, out_req_valid & exp_open());
    chk("R2 R3 out_req_ready", out_req_ready, tx_ready & exp_open());
    chk("R3 out_stall", out_stall, out_req_valid & !exp_open());
    chk("R2 R4 in_accept", in_accept, in_valid & ((m_d == 2'd0) | (in_kind != 2'd0)));
    chk("R4 in_drop", in_drop, in_valid & (m_d != 2'd0) & (in_kind == 2'd0));
    chk("R5 R7 dev_state", dev_state, m_d);
    chk("R8 R9 link_state", link_state, exp_link());
    chk("R5 cfg_reset", cfg_reset, m_pulse);
    chk("R5 link_retrain", link_retrain, m_pulse);
    chk("R6 to_ack_valid", to_ack_valid, m_ack);
    chk("R7 wake_oe", wake_oe, m_wake);
    chk("R10 turn_off_send", turn_off_send, m_toff);
  endtask

  task automatic step();
    logic [1:0] d_n;
    logic l23_n, ack_n, wake_n, pulse_n;
    #1 check_all();
    d_n = m_d; l23_n = m_l23; ack_n = m_ack; wake_n = 1'b0; pulse_n = 1'b0;
    if (m_l23) begin
      if (m_wake) begin l23_n = 1'b0; d_n = 2'd0; pulse_n = 1'b1; end
      else wake_n = wake_req;
    end else if (m_ack && to_ack_ready) begin
      l23_n = 1'b1; ack_n = 1'b0;
    end else begin
      if (cfg_pwr_wr) begin
        d_n = cfg_pwr_data;
        pulse_n = (m_d == 2'd3) && (cfg_pwr_data == 2'd0);
      end
      ack_n = (d_n == 2'd3) && (m_ack || (in_valid && in_kind == 2'd3 && m_d == 2'd3));
    end
    @(posedge clk);
    m_toff  = rc_mode && sw_turn_off && (m_d != 2'd0);
    m_l0s   = (d_n == 2'd0) && !l23_n && aspm_ctl[0] && link_idle;
    m_d = d_n; m_l23 = l23_n; m_ack = ack_n; m_wake = wake_n; m_pulse = pulse_n;
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_pwr_wr = 0; cfg_pwr_data = 0; aspm_ctl = 0; link_idle = 0; rc_mode = 0;
    sw_turn_off = 0; in_valid = 0; in_kind = 0; out_req_valid = 0; tx_ready = 1;
    to_ack_ready = 0; wake_req = 0;
  endtask

  task automatic write_state(input logic [1:0] s);
    idle(); cfg_pwr_wr = 1; cfg_pwr_data = s; step(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    idle();
    rst_n = 0;
    m_d = 0; m_l23 = 0; m_ack = 0; m_wake = 0; m_pulse = 0; m_l0s = 0; m_toff = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 dev_state", dev_state, 0);
    chk("R1 link_state", link_state, 0);
    chk("R1 pulses", {cfg_reset, link_retrain, to_ack_valid, wake_oe, turn_off_send}, 0);
    @(negedge clk);

    // R5: D3hot to D0 pulses, D1 to D0 does not
    write_state(2'd3);
    write_state(2'd0);
    chk("R5 pulse after D3hot->D0", {cfg_reset, link_retrain}, 2'b11);
    step();
    chk("R5 pulse lasts one cycle", cfg_reset, 0);
    write_state(2'd1);
    chk("R8 L1 in D1", link_state, 2);
    write_state(2'd0);
    chk("R5 no pulse after D1->D0", cfg_reset, 0);

    // R6 turn-off outside D3hot ignored, then handshake, R7 wake exit
    write_state(2'd2);
    in_valid = 1; in_kind = 2'd3; step(); idle();
    chk("R6 turn-off outside D3hot ignored", to_ack_valid, 0);
    write_state(2'd3);
    in_valid = 1; in_kind = 2'd3; step(); idle();
    chk("R6 ack raised", to_ack_valid, 1);
    step();
    chk("R6 ack held", to_ack_valid, 1);
    to_ack_ready = 1; step(); idle();
    chk("R6 L2/L3 entered", link_state, 3);
    write_state(2'd0);
    chk("R7 write ignored in L2/L3", dev_state, 3);
    wake_req = 1; step(); idle();
    chk("R7 wake_oe raised", wake_oe, 1);
    step();
    chk("R7 exit to D0", {dev_state, link_state}, 4'b0000);
    chk("R7 exit pulse", cfg_reset, 1);

    // R9 ASPM: L1 bit ignored, L0s bit honoured
    aspm_ctl = 2'b10; link_idle = 1; step(); step();
    chk("R9 L1 ASPM bit ignored", link_state, 0);
    aspm_ctl = 2'b01; step();
    chk("R9 L0s entered", link_state, 1);
    idle();

    // R10 root-complex turn-off command
    write_state(2'd2);
    rc_mode = 1; sw_turn_off = 1; step(); idle();
    chk("R10 turn_off_send", turn_off_send, 1);

    // R11 held request released on return to D0
    out_req_valid = 1; step();
    chk("R11 held while D2", out_stall, 1);
    cfg_pwr_wr = 1; cfg_pwr_data = 2'd0; step(); cfg_pwr_wr = 0;
    chk("R11 released in D0", tx_valid, 1);
    idle();

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      cfg_pwr_wr    = ($urandom_range(0, 9) == 0);
      cfg_pwr_data  = 2'($urandom_range(0, 3));
      aspm_ctl      = 2'($urandom_range(0, 3));
      link_idle     = 1'($urandom_range(0, 1));
      rc_mode       = 1'($urandom_range(0, 1));
      sw_turn_off   = ($urandom_range(0, 7) == 0);
      in_valid      = 1'($urandom_range(0, 1));
      in_kind       = 2'($urandom_range(0, 3));
      out_req_valid = 1'($urandom_range(0, 1));
      tx_ready      = 1'($urandom_range(0, 1));
      to_ack_ready  = 1'($urandom_range(0, 1));
      wake_req      = ($urandom_range(0, 9) == 0);
      step();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule